// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block drives a 10-bit analog-to-digital converter core from an 8-bit register port. The host can request one conversion on a chosen input channel with a single control write. It can instead let the block repeat conversions on a timer whose period is picked by a 3-bit rate field. Every finished conversion is formatted (left or right aligned, offset binary or two's complement) into a 16-bit result. The host reads that result as two bytes. A ready flag tells the host that a fresh result is waiting.

Repeating conversions have two flavours. In the overwrite flavour the result registers always hold the newest sample, and samples the host has not read are lost. In the hold flavour the sequencer stops after each result and waits until the host reads the high byte. That read clears the ready flag and lets the next conversion start, so the host paces the sampling by how often it reads. Toward the converter the block issues a one-cycle request together with the channel number, and it accepts a done strobe with the raw code.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Writing address 0 with bit 0 set starts one conversion on the channel held in bits 7:4 of the same byte. Bit 0 reads back as 1 until that conversion completes and as 0 afterwards. Bits 7:1 read back as written.
- R2: The ready flag `irq_ready` rises on the clock edge that samples `conv_done` and stays high until a read of address 2 (high byte). That read clears it, and a completing conversion on the same edge wins over the clear. A read of address 3 does not clear it.
- R3: With address 0 bit 1 set and bit 2 clear, conversion requests repeat every 2^(rate+4) clocks, where rate is address 1 bits 4:2. Each result overwrites the previous one, whether it was read or not. A new rate applies only once the converter is idle.
- R4: With address 0 bits 1 and 2 both set, no request is issued while the ready flag is high. A read of address 2 clears the flag, and conversion then resumes on its own.
- R5: With address 1 bits 1:0 = 00, the 16-bit result is the raw code right aligned with zero upper bits. High byte = result[15:8] at address 2, low byte = result[7:0] at address 3.
- R6: With address 1 bit 1 set (signed), the MSB of the raw code is inverted. A right-aligned signed result is sign extended into bits 15:10.
- R7: With address 1 bit 0 set (left aligned), the code occupies bits 15:6 and bits 5:0 are zero, so the high byte alone is the code truncated to its top 8 bits.
- R8: Clearing address 0 bit 1 during a conversion lets that conversion finish and store its result. No further request follows, and the result and the ready flag then stay unchanged.
- R9: After reset all four registers read 0, `irq_ready` is 0 and no request is pending.
- R10: `conv_req` is high for exactly one clock per conversion. `conv_chan` carries the channel that was selected when the request was issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 2 | Register address: 0 control, 1 format/rate, 2 result high, 3 result low |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| conv_req | output | 1 | One-cycle conversion request to the converter |
| conv_chan | output | 4 | Channel for the current conversion |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 10 | Raw converter code, valid with `conv_done` |
| irq_ready | output | 1 | Result ready flag |

## Verification
A start write sampled on edge k raises `conv_req` after edge k+1. The result bytes and `irq_ready` change on the edge that samples `conv_done`. A high-byte read sampled on edge r drops the flag after edge r. Repeating requests are spaced exactly 2^(rate+4) clocks apart. The bench drives inputs and samples outputs on falling edges. It waits on the converter stub's own request and done counters and on the flag rather than on fixed delays. It measures request spacing from the stub's time stamps. Each result it compares was stored at least one edge before it reads it.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } seq_state_t;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_CONF = 2'd1;
   localparam logic [1:0] ADR_RESH = 2'd2;
   localparam logic [1:0] ADR_RESL = 2'd3;

   localparam int CTRL_BIT_SGL   = 0;
   localparam int CTRL_BIT_CONT  = 1;
   localparam int CTRL_BIT_HOLD  = 2;
   localparam int CONF_BIT_LEFT  = 0;
   localparam int CONF_BIT_SIGN  = 1;
   localparam int CONF_RATE_LSB  = 2;

endpackage

// File: rtl/adc_rate_timer.sv
`timescale 1ns/1ps
module adc_rate_timer #(
   parameter int RATE_W    = 3,
   parameter int BASE_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic              busy,
   input  logic [RATE_W-1:0] rate,
   output logic              elapsed
);
   localparam int CNT_W = BASE_LOG2 + (1 << RATE_W) + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("adc_rate_timer: BASE_LOG2 must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] period_q;
   logic [CNT_W-1:0] period_next;

   assign period_next = ONE << (CNT_W'(rate) + CNT_W'(BASE_LOG2));
   assign elapsed     = (cnt_q >= (period_q - ONE));

   // The period only follows the rate field while no conversion is running.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         period_q <= ONE << BASE_LOG2;
      end else begin
         if (!busy) begin
            period_q <= period_next;
         end
         if (!run || restart) begin
            cnt_q <= '0;
         end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + ONE;
         end
      end
   end

   // R3: a fresh interval never ends on the cycle after it began
   p_min_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !elapsed);

endmodule

// File: rtl/adc_result_fmt.sv
`timescale 1ns/1ps
module adc_result_fmt #(
   parameter int ADC_W = 10,
   parameter int OUT_W = 16
) (
   input  logic [ADC_W-1:0] raw,
   input  logic             left_align,
   input  logic             signed_fmt,
   output logic [OUT_W-1:0] res
);
   localparam int PAD_W = OUT_W - ADC_W;

   if (PAD_W < 1) begin : g_bad_width
      $error("adc_result_fmt: OUT_W must exceed ADC_W");
   end

   logic [ADC_W-1:0] code;
   logic [OUT_W-1:0] left_v;
   logic [OUT_W-1:0] right_v;

   // Offset binary to two's complement by flipping the top bit.
   assign code = {raw[ADC_W-1] ^ signed_fmt, raw[ADC_W-2:0]};

   for (genvar i = 0; i < OUT_W; i++) begin : g_bit
      if (i < PAD_W) begin : g_left_pad
         assign left_v[i] = 1'b0;
      end else begin : g_left_code
         assign left_v[i] = code[i-PAD_W];
      end
      if (i < ADC_W) begin : g_right_code
         assign right_v[i] = code[i];
      end else begin : g_right_ext
         assign right_v[i] = signed_fmt & code[ADC_W-1];
      end
   end

   assign res = left_align ? left_v : right_v;

endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
   import adc_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sgl_req,
   input  logic cont_ok,
   input  logic conv_done,
   output logic launch,
   output logic busy,
   output logic done_store,
   output logic single_done,
   output logic conv_req
);
   seq_state_t st_q;
   logic       is_sgl_q;
   logic       req_q;

   assign launch      = (st_q == ST_IDLE) && (sgl_req || cont_ok);
   assign busy        = (st_q == ST_BUSY);
   assign done_store  = busy && conv_done;
   assign single_done = done_store && is_sgl_q;
   assign conv_req    = req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         is_sgl_q <= 1'b0;
         req_q    <= 1'b0;
      end else begin
         req_q <= launch;
         unique case (st_q)
            ST_IDLE: begin
               if (launch) begin
                  st_q     <= ST_BUSY;
                  is_sgl_q <= sgl_req;
               end
            end
            ST_BUSY: begin
               if (conv_done) begin
                  st_q <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R10: the request to the converter lasts one clock
   p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> !conv_req);

   // R10: a request is only issued from the idle state
   p_req_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> $past(!busy));

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int REG_W     = 8,
   parameter int ADC_W     = 10,
   parameter int CH_W      = 4,
   parameter int RATE_W    = 3,
   parameter int BASE_LOG2 = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             conv_req,
   output logic [CH_W-1:0]  conv_chan,
   input  logic             conv_done,
   input  logic [ADC_W-1:0] conv_data,
   output logic             irq_ready
);
   localparam int RES_W = 2 * REG_W;

   if (ADC_W <= REG_W || ADC_W > RES_W) begin : g_bad_adc
      $error("adc_seq_ctrl: ADC_W must lie between REG_W+1 and 2*REG_W");
   end
   if (CH_W + 3 > REG_W) begin : g_bad_chan
      $error("adc_seq_ctrl: channel field does not fit the control byte");
   end
   if (RATE_W + CONF_RATE_LSB > REG_W) begin : g_bad_rate
      $error("adc_seq_ctrl: rate field does not fit the format byte");
   end

   logic             sgl_q;
   logic [REG_W-1:1] ctrl_q;
   logic [REG_W-1:0] conf_q;
   logic             rdy_q;
   logic [RES_W-1:0] res_q;
   logic [CH_W-1:0]  chan_q;

   logic wr_ctrl, wr_conf, rd_resh, wr_sgl;
   logic cont_en, hold_mode, cont_ok;
   logic launch, busy, done_store, single_done, elapsed;
   logic [CH_W-1:0]   chan_sel;
   logic [RATE_W-1:0] rate;
   logic [RES_W-1:0]  fmt_res;

   assign wr_ctrl   = reg_wr && (reg_addr == ADR_CTRL);
   assign wr_conf   = reg_wr && (reg_addr == ADR_CONF);
   assign rd_resh   = reg_rd && (reg_addr == ADR_RESH);
   assign wr_sgl    = wr_ctrl && reg_wdata[CTRL_BIT_SGL];

   assign cont_en   = ctrl_q[CTRL_BIT_CONT];
   assign hold_mode = ctrl_q[CTRL_BIT_HOLD];
   assign chan_sel  = ctrl_q[REG_W-1 -: CH_W];
   assign rate      = conf_q[CONF_RATE_LSB +: RATE_W];
   assign cont_ok   = cont_en && elapsed && !(hold_mode && rdy_q);

   adc_rate_timer #(
      .RATE_W    (RATE_W),
      .BASE_LOG2 (BASE_LOG2)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (cont_en),
      .restart (launch),
      .busy    (busy),
      .rate    (rate),
      .elapsed (elapsed)
   );

   adc_seq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sgl_req     (sgl_q),
      .cont_ok     (cont_ok),
      .conv_done   (conv_done),
      .launch      (launch),
      .busy        (busy),
      .done_store  (done_store),
      .single_done (single_done),
      .conv_req    (conv_req)
   );

   adc_result_fmt #(
      .ADC_W (ADC_W),
      .OUT_W (RES_W)
   ) u_fmt (
      .raw        (conv_data),
      .left_align (conf_q[CONF_BIT_LEFT]),
      .signed_fmt (conf_q[CONF_BIT_SIGN]),
      .res        (fmt_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sgl_q  <= 1'b0;
         ctrl_q <= '0;
         conf_q <= '0;
         rdy_q  <= 1'b0;
         res_q  <= '0;
         chan_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q <= reg_wdata[REG_W-1:1];
         end
         if (wr_conf) begin
            conf_q <= reg_wdata;
         end
         if (wr_sgl) begin
            sgl_q <= 1'b1;
         end else if (single_done) begin
            sgl_q <= 1'b0;
         end
         if (done_store) begin
            rdy_q <= 1'b1;
         end else if (rd_resh) begin
            rdy_q <= 1'b0;
         end
         if (done_store) begin
            res_q <= fmt_res;
         end
         if (launch) begin
            chan_q <= chan_sel;
         end
      end
   end

   always_comb begin
      unique case (reg_addr)
         ADR_CTRL: reg_rdata = {ctrl_q, sgl_q};
         ADR_CONF: reg_rdata = conf_q;
         ADR_RESH: reg_rdata = res_q[RES_W-1 -: REG_W];
         ADR_RESL: reg_rdata = res_q[REG_W-1:0];
         default:  reg_rdata = '0;
      endcase
   end

   assign conv_chan = chan_q;
   assign irq_ready = rdy_q;

   // R2: a completed conversion raises the flag
   p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_store |=> irq_ready);

   // R2: without completion or a high-byte read the flag holds
   p_flag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_store && !rd_resh) |=> $stable(irq_ready));

   // R1: the start bit drops once its own conversion finishes
   p_sgl_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (single_done && !wr_sgl) |=> !sgl_q);

   // R8: result bytes only move when a conversion completes
   p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_store |=> $stable(res_q));

   // R4: hold mode issues nothing while an unread result waits
   p_hold_no_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cont_en && hold_mode && irq_ready && !sgl_q) |=> !conv_req);

endmodule

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

   localparam int LAT = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       conv_req;
   logic [3:0] conv_chan;
   logic       conv_done = 1'b0;
   logic [9:0] conv_data = 10'd0;
   logic       irq_ready;

   int     n_chk = 0;
   int     n_fail = 0;
   int     stub_cnt = 0;
   int     n_req = 0;
   int     n_done = 0;
   longint cyc = 0;
   longint last_req = 0;
   longint prev_req = 0;
   logic [9:0] stub_data = 10'd0;
   logic [3:0] req_chan = 4'd0;
   bit         use_fixed = 1'b0;
   logic [9:0] fixed_val = 10'd0;
   logic [9:0] next_v;

   adc_seq_ctrl i_adc_seq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .conv_req  (conv_req),
      .conv_chan (conv_chan),
      .conv_done (conv_done),
      .conv_data (conv_data),
      .irq_ready (irq_ready)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // Behavioural converter: answers each request LAT clocks later.
   always @(posedge clk) begin
      conv_done <= 1'b0;
      if (conv_req) begin
         stub_cnt <= LAT;
         n_req    <= n_req + 1;
         prev_req <= last_req;
         last_req <= cyc;
         req_chan <= conv_chan;
      end else if (stub_cnt > 1) begin
         stub_cnt <= stub_cnt - 1;
      end else if (stub_cnt == 1) begin
         next_v = use_fixed ? fixed_val : 10'($urandom_range(0, 1023));
         stub_cnt  <= 0;
         conv_done <= 1'b1;
         conv_data <= next_v;
         stub_data <= next_v;
         n_done    <= n_done + 1;
      end
   end

   function automatic logic [15:0] exp_fmt(logic [9:0] raw, bit lj, bit sg);
      logic [9:0] v;
      v = sg ? (raw ^ 10'h200) : raw;
      if (lj) return {v, 6'b0};
      if (sg) return {{6{v[9]}}, v};
      return {6'b0, v};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      reg_rd   = 1'b1;
      #1;
      d = reg_rdata;
      @(negedge clk);
      reg_rd   = 1'b0;
   endtask

   task automatic wait_ready(input string tag);
      int i;
      i = 0;
      while (!irq_ready && i < 5000) begin
         @(negedge clk);
         i++;
      end
      chk(tag, 32'(irq_ready), 32'd1);
   endtask

   task automatic wait_reqs(input int target);
      int i;
      i = 0;
      while (n_req < target && i < 20000) begin
         @(negedge clk);
         i++;
      end
   endtask

   task automatic wait_done_change();
      int d0;
      int i;
      d0 = n_done;
      i = 0;
      while (n_done == d0 && i < 20000) begin
         @(negedge clk);
         i++;
      end
   endtask

   // One single conversion with full readback checks.
   task automatic single_conv(input bit lj, input bit sg, input logic [3:0] ch);
      logic [7:0]  d;
      logic [15:0] e;
      int          base;
      string       ftag;
      ftag = lj ? "R7 left aligned" : (sg ? "R6 signed right" : "R5 unsigned right");
      if (lj && sg) ftag = "R6/R7 signed left";
      wr(2'd1, {6'b0, sg, lj});
      base = n_req;
      wr(2'd0, {ch, 4'b0001});
      rd(2'd0, d);
      chk("R1 start bit reads 1 while converting", 32'(d[0]), 32'd1);
      wait_ready("R2 flag after single conversion");
      chk("R10 one request per single conversion", 32'(n_req), 32'(base + 1));
      chk("R10 channel with request", 32'(req_chan), 32'(ch));
      rd(2'd0, d);
      chk("R1 start bit self-clears, other bits kept", 32'(d), 32'({ch, 4'b0000}));
      e = exp_fmt(stub_data, lj, sg);
      rd(2'd3, d);
      chk({ftag, " low byte"}, 32'(d), 32'(e[7:0]));
      chk("R2 low byte read leaves flag", 32'(irq_ready), 32'd1);
      rd(2'd2, d);
      chk({ftag, " high byte"}, 32'(d), 32'(e[15:8]));
      chk("R2 high byte read clears flag", 32'(irq_ready), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0]  d;
      logic [15:0] e;
      logic [9:0]  corner [4];
      int          base;
      void'($urandom(32'd20240611));
      corner[0] = 10'h000;
      corner[1] = 10'h3FF;
      corner[2] = 10'h200;
      corner[3] = 10'h1FF;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset state
      chk("R9 flag after reset", 32'(irq_ready), 32'd0);
      chk("R9 no request after reset", 32'(conv_req), 32'd0);
      rd(2'd0, d); chk("R9 control after reset", 32'(d), 32'd0);
      rd(2'd1, d); chk("R9 format after reset", 32'(d), 32'd0);
      rd(2'd2, d); chk("R9 high byte after reset", 32'(d), 32'd0);
      rd(2'd3, d); chk("R9 low byte after reset", 32'(d), 32'd0);

      // Directed corner codes under every format setting (R5, R6, R7)
      use_fixed = 1'b1;
      for (int k = 0; k < 4; k++) begin
         for (int f = 0; f < 4; f++) begin
            fixed_val = corner[k];
            single_conv(f[0], f[1], 4'(k * 4 + f));
         end
      end

      // Random codes, channels and formats
      use_fixed = 1'b0;
      for (int n = 0; n < 24; n++) begin
         single_conv(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     4'($urandom_range(0, 15)));
      end

      // R3: repeating conversions, overwrite flavour, rate 0 then rate 2
      wr(2'd1, 8'h00);
      base = n_req;
      wr(2'd0, {4'h2, 4'b0010});
      wait_reqs(base + 3);
      chk("R3 period at rate 0", 32'(last_req - prev_req), 32'd16);
      wr(2'd1, {3'b0, 3'd2, 2'b00});
      base = n_req;
      wait_reqs(base + 3);
      chk("R3 period at rate 2", 32'(last_req - prev_req), 32'd64);
      chk("R10 channel in repeating mode", 32'(req_chan), 32'd2);
      wait_done_change();
      @(negedge clk);
      e = exp_fmt(stub_data, 1'b0, 1'b0);
      chk("R3 flag still set with unread results", 32'(irq_ready), 32'd1);
      rd(2'd3, d); chk("R3 newest result overwrote, low", 32'(d), 32'(e[7:0]));
      rd(2'd2, d); chk("R3 newest result overwrote, high", 32'(d), 32'(e[15:8]));

      // R8: stop repeating during a conversion
      base = n_req;
      wait_reqs(base + 1);
      wr(2'd0, {4'h2, 4'b0000});
      wait_done_change();
      repeat (2) @(negedge clk);
      chk("R8 last conversion sets flag", 32'(irq_ready), 32'd1);
      base = n_req;
      e = exp_fmt(stub_data, 1'b0, 1'b0);
      repeat (300) @(negedge clk);
      chk("R8 no request after stop", 32'(n_req), 32'(base));
      chk("R8 flag unchanged after stop", 32'(irq_ready), 32'd1);
      rd(2'd3, d); chk("R8 last result stored, low", 32'(d), 32'(e[7:0]));
      rd(2'd2, d); chk("R8 last result stored, high", 32'(d), 32'(e[15:8]));

      // R4: hold-until-read flavour
      wr(2'd1, 8'h00);
      wr(2'd0, {4'h5, 4'b0110});
      wait_ready("R4 first held result");
      base = n_req;
      e = exp_fmt(stub_data, 1'b0, 1'b0);
      repeat (200) @(negedge clk);
      chk("R4 no request while result unread", 32'(n_req), 32'(base));
      chk("R4 flag held", 32'(irq_ready), 32'd1);
      rd(2'd3, d); chk("R4 held result not overwritten, low", 32'(d), 32'(e[7:0]));
      rd(2'd2, d); chk("R4 held result not overwritten, high", 32'(d), 32'(e[15:8]));
      wait_ready("R4 read restarts conversion");
      chk("R4 exactly one new request after read", 32'(n_req), 32'(base + 1));
      chk("R10 channel in hold mode", 32'(req_chan), 32'd5);
      wr(2'd0, 8'h00);
      repeat (40) @(negedge clk);
      rd(2'd2, d);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule